// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This unit takes two IEEE-754 binary64 operands and classifies how they relate. It returns a one-hot condition code that says less, greater, equal or unordered. Two flags report invalid-operation events: one for a signalling NaN operand, and one for a NaN seen by an ordered compare. A mode bit selects between quiet (unordered) and ordered semantics. Both modes use the same datapath.

Operands are accepted when the input strobe is high. The result is registered, so the output strobe and the result come one clock after the inputs. Subnormals are compared exactly, with no flushing. The magnitude test is an unsigned compare of the low 63 bits, which hold the exponent and the fraction.

Top module: `fp_cmp64`

## Requirements
- R1: The condition code `cc_o` is one-hot, with bit 3 = less, bit 2 = greater, bit 1 = equal and bit 0 = unordered. Whenever `res_vld_o` is high, exactly one bit is set.
- R2: If either operand is a NaN, `cc_o` is 4'b0001. A NaN has exponent bits [62:52] all ones and a nonzero fraction [51:0].
- R3: A signalling NaN sets `snan_inv_o` in both modes. A signalling NaN is a NaN whose bit 51 is 0. Quiet NaNs (bit 51 = 1) leave this flag clear.
- R4: When `ordered_i` = 1, any NaN operand sets `cmp_inv_o`. When `ordered_i` = 0, `cmp_inv_o` stays 0.
- R5: Two zeros of any sign compare equal (4'b0010).
- R6: If the signs differ and the operands are not both zero, the negative operand is less. `cc_o` is 4'b1000 when A is negative and 4'b0100 when B is negative.
- R7: With equal positive signs, a larger magnitude compares greater. The magnitude order is infinity > finite nonzero > zero, and subnormals are ordered exactly. With equal negative signs, less and greater are swapped.
- R8: Identical magnitudes with the same sign compare equal. This includes two infinities of the same sign.
- R9: `res_vld_o` follows `vld_i` by exactly one clock, and the result and flags belong to the operands sampled on that edge. After reset, `res_vld_o` is 0 and `cc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Operands valid |
| ordered_i | input | 1 | 1 = ordered compare, 0 = unordered compare |
| opa_i | input | 64 | Operand A (binary64) |
| opb_i | input | 64 | Operand B (binary64) |
| res_vld_o | output | 1 | Result valid, one clock after vld_i |
| cc_o | output | 4 | One-hot {less, greater, equal, unordered} |
| snan_inv_o | output | 1 | Signalling-NaN invalid flag |
| cmp_inv_o | output | 1 | Ordered-compare invalid flag |

## Verification
The assertions assume only that `vld_i` is a clean level sampled at the edge. They place no condition on the operand values: every 64-bit pattern has a defined result. The one-hot and flag properties are therefore checked on every valid result. The stimulus changes the inputs only on the falling clock edge, so each sampled operand pair is stable. The stimulus covers quiet and signalling NaNs, zeros of both signs, subnormals, infinities and mixed signs in both modes, and then a sweep of patterned values.

// File: rtl/fp_cmp64.sv
module fp_cmp64 #(
  parameter int EXP_W = 11,
  parameter int FRAC_W = 52,
  localparam int W = EXP_W + FRAC_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic         ordered_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         res_vld_o,
  output logic [3:0]   cc_o,
  output logic         snan_inv_o,
  output logic         cmp_inv_o
);
  localparam int MAG_W = W - 1;

  logic sa, sb;
  logic [MAG_W-1:0] ma, mb;
  assign sa = opa_i[W-1];
  assign sb = opb_i[W-1];
  assign ma = opa_i[MAG_W-1:0];
  assign mb = opb_i[MAG_W-1:0];

  logic nan_a, nan_b, snan_a, snan_b, zero_a, zero_b;
  assign nan_a  = (&opa_i[W-2:FRAC_W]) && (|opa_i[FRAC_W-1:0]);
  assign nan_b  = (&opb_i[W-2:FRAC_W]) && (|opb_i[FRAC_W-1:0]);
  assign snan_a = nan_a && !opa_i[FRAC_W-1];
  assign snan_b = nan_b && !opb_i[FRAC_W-1];
  assign zero_a = (ma == '0);
  assign zero_b = (mb == '0);

  logic any_nan;
  logic [3:0] cc_n;
  assign any_nan = nan_a || nan_b;

  always_comb begin
    if (any_nan)                 cc_n = 4'b0001;
    else if (zero_a && zero_b)   cc_n = 4'b0010;
    else if (sa != sb)           cc_n = sa ? 4'b1000 : 4'b0100;
    else if (ma == mb)           cc_n = 4'b0010;
    else if ((ma < mb) ^ sa)     cc_n = 4'b1000;
    else                         cc_n = 4'b0100;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o  <= 1'b0;
      cc_o       <= '0;
      snan_inv_o <= 1'b0;
      cmp_inv_o  <= 1'b0;
    end else begin
      res_vld_o <= vld_i;
      if (vld_i) begin
        cc_o       <= cc_n;
        snan_inv_o <= snan_a || snan_b;
        cmp_inv_o  <= ordered_i && any_nan;
      end
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $onehot(cc_o));
  p_snan_unord_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && snan_inv_o) |-> cc_o == 4'b0001);
  p_inv_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && cmp_inv_o) |-> cc_o == 4'b0001);
  p_quiet_noinv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !ordered_i) |=> !cmp_inv_o);
  p_vld_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> res_vld_o);
  p_novld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !res_vld_o);
  p_zero_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && opa_i[W-2:0] == '0 && opb_i[W-2:0] == '0) |=> cc_o == 4'b0010);
endmodule

// File: tb/fp_cmp64_tb_top.sv
module fp_cmp64_tb_top;
  logic clk = 0, rst_n = 0, vld_i = 0, ordered_i = 0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic res_vld_o, snan_inv_o, cmp_inv_o;
  logic [3:0] cc_o;

  fp_cmp64 dut_i (.*);

  always #5 clk = ~clk;

  typedef struct { logic [3:0] cc; logic sn; logic iv; string req; } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] SUB1 = 64'h0000_0000_0000_0001;
  localparam logic [63:0] SUB2 = 64'h0000_0000_0000_0002;

  function automatic bit is_nan(logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction

  function automatic exp_t model(logic [63:0] a, logic [63:0] b, logic ord, string req);
    exp_t e;
    real ra, rb;
    e.req = req;
    e.sn = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    e.iv = ord && (is_nan(a) || is_nan(b));
    if (is_nan(a) || is_nan(b)) e.cc = 4'b0001;
    else begin
      ra = $bitstoreal(a); rb = $bitstoreal(b);
      if (ra < rb) e.cc = 4'b1000;
      else if (ra > rb) e.cc = 4'b0100;
      else e.cc = 4'b0010;
    end
    return e;
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic ord, string req);
    @(negedge clk);
    opa_i = a; opb_i = b; ordered_i = ord; vld_i = 1;
    q.push_back(model(a, b, ord, req));
    @(negedge clk);
    vld_i = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld_o) begin
      exp_t e;
      compared++;
      if (q.size() == 0) begin
        mismatched++;
        $display("FAIL R9: unexpected result valid, actual cc=%b expected none", cc_o);
      end else begin
        e = q.pop_front();
        if (cc_o !== e.cc || snan_inv_o !== e.sn || cmp_inv_o !== e.iv) begin
          mismatched++;
          $display("FAIL %s: actual cc=%b sn=%b iv=%b expected cc=%b sn=%b iv=%b",
                   e.req, cc_o, snan_inv_o, cmp_inv_o, e.cc, e.sn, e.iv);
        end
      end
    end
  end

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1;
    compared++;
    if (res_vld_o !== 1'b0 || cc_o !== 4'b0) begin
      mismatched++;
      $display("FAIL R9: reset actual vld=%b cc=%b expected 0/0000", res_vld_o, cc_o);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(QNAN, ONE, 0, "R2");
    drive(ONE, QNAN, 1, "R4");
    drive(SNAN, ONE, 0, "R3");
    drive(ONE, SNAN, 1, "R3");
    drive(QNAN, QNAN, 0, "R2");
    drive(PZ, NZ, 0, "R5");
    drive(NZ, PZ, 1, "R5");
    drive(NZ, ONE, 0, "R6");
    drive(ONE, NZ, 0, "R6");
    drive(NINF, PINF, 0, "R6");
    drive(PZ, SUB1, 0, "R7");
    drive(SUB2, SUB1, 0, "R7");
    drive(ONE, TWO, 0, "R7");
    drive(ONE | NZ, TWO | NZ, 0, "R7");
    drive(PINF, TWO, 1, "R7");
    drive(NINF, TWO | NZ, 0, "R7");
    drive(PINF, PINF, 0, "R8");
    drive(NINF, NINF, 1, "R8");
    drive(TWO, TWO, 0, "R8");
    drive(SUB1 | NZ, SUB2 | NZ, 0, "R7");
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      a = {i[0], 11'(i * 37 + 900), 52'(i * 64'h1_2345_6789)};
      b = {i[1], 11'(i * 41 + 880), 52'(i * 64'h9_8765_4321)};
      drive(a, b, i[2], "R1");
    end
    @(negedge clk);
    opa_i = ONE; opb_i = TWO;
    repeat (2) @(negedge clk);
    compared++;
    if (res_vld_o !== 0 || q.size() != 0) begin
      mismatched++;
      $display("FAIL R9: idle actual vld=%b pending=%0d expected 0/0", res_vld_o, q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule